// File: doc/BRIEF.md
# External Interrupt and Wake-up Controller

This block gathers external interrupt pins into interrupt requests and a wake-up signal. It has two groups of inputs. The first is a set of edge-triggered channels, each with its own request output. Each can be programmed to respond to rising edges, falling edges or both. The second is a single request shared by a group of active-low, level-sensitive inputs, each of which can be masked on its own.

Edge capture uses flip-flops clocked by the pin itself, so an edge is recorded even while the system clock is stopped. A synchronizer chain then carries the capture into the clock domain. The wake-up output is combinational from the captures and the level inputs, so it can restart a stopped clock.

Each edge channel is run by a small state machine with three states. `CH_IDLE` waits for a synchronized capture and goes to `CH_PENDING` (transition *capture-seen*). `CH_PENDING` holds the flag until software writes 0 to it and then goes to `CH_CLEARING` (transition *sw-clear*). `CH_CLEARING` clears the capture flops and the synchronizer for one cycle and returns to `CH_IDLE` (transition *clear-done*). The reset state is `CH_IDLE`.

Register map, 8-bit data, 2-bit address:
- address 0: edge mode, two bits per channel at bits [2i+1:2i]. Bit 0 of the pair enables rising edges and bit 1 enables falling edges, so 00 is off, 01 rising, 10 falling and 11 both.
- address 1: the edge request enables sit at bits [2:0]. The flags sit at bits [6:4] and read as 1 while a channel is `CH_PENDING`. Writing 0 to a flag bit clears it and writing 1 has no effect.
- address 2: the level input enables, bits [7:0].
- address 3 (read only): level inputs that are enabled and low, bits [7:0].

Top module: `xwk_ctrl`

## Requirements
- R1: After reset, all four addresses read 0, no edge request or level request is active, and wake is 0.
- R2: With mode bit 0 set (mode 01 or 11), a rising edge on a channel's pin sets its flag (address 1 bit 4+i). With mode 00 or 10, a rising edge leaves the flag at 0.
- R3: With mode bit 1 set (mode 10 or 11), a falling edge sets the flag. With mode 00 or 01, a falling edge leaves the flag at 0.
- R4: A flag reads 1 no later than the fourth clock rising edge after the pin edge. It stays set until software writes 0 to its bit at address 1. Writing 1 to the bit leaves the flag set.
- R5: The edge request output i is 1 exactly when flag i and enable i (address 1 bit i) are both 1.
- R6: An edge on an enabled channel while the clock is stopped drives wake to 1 with no clock edge. The flag and request then appear once the clock runs again.
- R7: After a flag is cleared, it reads 0 and wake drops. A new edge sets the flag again.
- R8: The level request is the OR over inputs i of (enable i AND input i low). It is not latched, and address 3 reads these per-input terms.
- R9: wake is the OR of the level request and of every enabled edge channel's capture. It works while the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_pin | input | N_EDGE | Edge-triggered interrupt pins |
| lvl_pin_n | input | N_LVL | Active-low level-triggered pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| edge_irq | output | N_EDGE | Per-channel edge interrupt requests |
| lvl_irq | output | 1 | Shared level interrupt request |
| wake | output | 1 | Combinational wake-up request |

## Verification
The bench sweeps every channel through every mode with both edge directions. A swapped mode bit or a missing both-edges path therefore shows up as a flag set or missed in a specific cell of the sweep. It stops the clock and toggles pins to show that wake rises with no clock edge and that the flag appears only after restart; a design that captured edges with the system clock would stay silent. It writes 1 to a set flag, which a careless clear decode would treat as a clear. It also covers all 65,536 combinations of level enable and pin, where a polarity or masking error flips the request.

// File: rtl/xwk_pkg.sv
package xwk_pkg;
    typedef enum logic [1:0] {
        CH_IDLE     = 2'b00,
        CH_PENDING  = 2'b01,
        CH_CLEARING = 2'b10
    } chan_st_t;

    localparam logic [1:0] ADDR_MODE    = 2'd0;
    localparam logic [1:0] ADDR_CTRL    = 2'd1;
    localparam logic [1:0] ADDR_LVLEN   = 2'd2;
    localparam logic [1:0] ADDR_LVLSTAT = 2'd3;
    localparam int         FLAG_LSB     = 4;
endpackage

// File: rtl/xwk_edge_chan.sv
module xwk_edge_chan
    import xwk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    input  logic       en,
    input  logic       clr_req,
    output logic       flag,
    output logic       irq,
    output logic       wake_req
);
    chan_st_t               state, state_nx;
    logic                   cap_rst;
    logic                   rise_cap, fall_cap, cap_any;
    logic [SYNC_STAGES-1:0] sync_q;

    // bit 1 of the state code marks CH_CLEARING: a single flop bit, glitch free
    assign cap_rst = ~rst_n | state[1];

    // pin-clocked capture works with the system clock stopped
    always_ff @(posedge pin or posedge cap_rst) begin
        if (cap_rst) rise_cap <= 1'b0;
        else         rise_cap <= rise_cap | mode[0];
    end

    always_ff @(negedge pin or posedge cap_rst) begin
        if (cap_rst) fall_cap <= 1'b0;
        else         fall_cap <= fall_cap | mode[1];
    end

    assign cap_any = rise_cap | fall_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      sync_q <= '0;
        else if (state == CH_CLEARING)   sync_q <= '0;
        else                             sync_q <= {sync_q[SYNC_STAGES-2:0], cap_any};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:     if (sync_q[SYNC_STAGES-1]) state_nx = CH_PENDING;
            CH_PENDING:  if (clr_req)               state_nx = CH_CLEARING;
            CH_CLEARING:                            state_nx = CH_IDLE;
            default:                                state_nx = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag     = (state == CH_PENDING);
        irq      = flag & en;
        wake_req = cap_any & en;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PENDING && !clr_req) |=> (state == CH_PENDING)); // R4
    AST_FLAG_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sync_q[SYNC_STAGES-1])); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_CLEARING) |=> !flag); // R7
endmodule

// File: rtl/xwk_level_grp.sv
module xwk_level_grp #(
    parameter int N_LVL = 8
) (
    input  logic [N_LVL-1:0] lvl_pin_n,
    input  logic [N_LVL-1:0] lvl_en,
    output logic [N_LVL-1:0] active,
    output logic             req
);
    for (genvar i = 0; i < N_LVL; i++) begin : g_in
        assign active[i] = lvl_en[i] & ~lvl_pin_n[i];
    end
    assign req = |active;
endmodule

// File: rtl/xwk_regs.sv
module xwk_regs
    import xwk_pkg::*;
#(
    parameter int N_EDGE = 3,
    parameter int N_LVL  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic [N_EDGE-1:0]   flags,
    input  logic [N_LVL-1:0]    lvl_active,
    output logic [7:0]          reg_rdata,
    output logic [2*N_EDGE-1:0] edge_mode,
    output logic [N_EDGE-1:0]   edge_en,
    output logic [N_LVL-1:0]    lvl_en,
    output logic [N_EDGE-1:0]   flag_clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_mode <= '0;
            edge_en   <= '0;
            lvl_en    <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADDR_MODE:    edge_mode <= reg_wdata[2*N_EDGE-1:0];
                ADDR_CTRL:    edge_en   <= reg_wdata[N_EDGE-1:0];
                ADDR_LVLEN:   lvl_en    <= reg_wdata[N_LVL-1:0];
                ADDR_LVLSTAT: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_EDGE; i++) begin : g_clr
        assign flag_clr[i] = reg_wr && (reg_addr == ADDR_CTRL) && !reg_wdata[FLAG_LSB+i];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_MODE:    reg_rdata[2*N_EDGE-1:0] = edge_mode;
            ADDR_CTRL: begin
                reg_rdata[N_EDGE-1:0]                 = edge_en;
                reg_rdata[FLAG_LSB+N_EDGE-1:FLAG_LSB] = flags;
            end
            ADDR_LVLEN:   reg_rdata[N_LVL-1:0] = lvl_en;
            ADDR_LVLSTAT: reg_rdata[N_LVL-1:0] = lvl_active;
        endcase
    end
endmodule

// File: rtl/xwk_ctrl.sv
module xwk_ctrl
    import xwk_pkg::*;
#(
    parameter int N_EDGE      = 3,
    parameter int N_LVL       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EDGE-1:0] edge_pin,
    input  logic [N_LVL-1:0]  lvl_pin_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [N_EDGE-1:0] edge_irq,
    output logic              lvl_irq,
    output logic              wake
);
    logic [2*N_EDGE-1:0] edge_mode;
    logic [N_EDGE-1:0]   edge_en, flag_clr, flags, edge_wake;
    logic [N_LVL-1:0]    lvl_en, lvl_active;

    xwk_regs #(.N_EDGE(N_EDGE), .N_LVL(N_LVL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .flags      (flags),
        .lvl_active (lvl_active),
        .reg_rdata  (reg_rdata),
        .edge_mode  (edge_mode),
        .edge_en    (edge_en),
        .lvl_en     (lvl_en),
        .flag_clr   (flag_clr)
    );

    for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
        xwk_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (edge_pin[i]),
            .mode     (edge_mode[2*i+1:2*i]),
            .en       (edge_en[i]),
            .clr_req  (flag_clr[i]),
            .flag     (flags[i]),
            .irq      (edge_irq[i]),
            .wake_req (edge_wake[i])
        );
    end

    xwk_level_grp #(.N_LVL(N_LVL)) u_lvl (
        .lvl_pin_n (lvl_pin_n),
        .lvl_en    (lvl_en),
        .active    (lvl_active),
        .req       (lvl_irq)
    );

    assign wake = (|edge_wake) | lvl_irq;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_irq & ~edge_en) == '0)); // R5
    AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((|edge_irq) || lvl_irq) |-> wake); // R9
    AST_LVL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&lvl_pin_n) |-> !lvl_irq); // R8
    AST_LVL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_en == '0) |-> !lvl_irq); // R8
endmodule

// File: tb/xwk_ctrl_tb.sv
module xwk_ctrl_tb;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [2:0] edge_pin = '0;
    logic [7:0] lvl_pin_n = '1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] edge_irq;
    logic       lvl_irq, wake;
    int         n_vec = 0, n_bad = 0;
    logic [7:0] rd;

    xwk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .edge_pin(edge_pin), .lvl_pin_n(lvl_pin_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .edge_irq(edge_irq), .lvl_irq(lvl_irq), .wake(wake)
    );

    // 125 MHz, gateable to model stop mode
    always begin
        #4;
        if (clk_run) clk = ~clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rdreg(a[1:0], rd);
            check("R1 reg", {24'd0, rd}, 32'd0);
        end
        check("R1 edge_irq", {29'd0, edge_irq}, 32'd0);
        check("R1 lvl_irq", {31'd0, lvl_irq}, 32'd0);
        check("R1 wake", {31'd0, wake}, 32'd0);

        // R2/R3: every channel x mode x direction
        for (int ch = 0; ch < 3; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic exp;
                    wr(2'd0, 8'h00);
                    edge_pin[ch] = dir[0];
                    settle(2);
                    wr(2'd1, 8'h07);                 // clear all flags, enable all
                    settle(3);
                    wr(2'd0, 8'(m << (2 * ch)));
                    edge_pin[ch] = ~dir[0];
                    settle(4);
                    exp = dir[0] ? m[1] : m[0];
                    rdreg(2'd1, rd);
                    if (dir == 0) check("R2 rise flag", {31'd0, rd[4+ch]}, {31'd0, exp});
                    else          check("R3 fall flag", {31'd0, rd[4+ch]}, {31'd0, exp});
                    check("R5 irq", {29'd0, edge_irq}, {29'd0, 3'(exp) << ch});
                    check("R9 wake edge", {31'd0, wake}, {31'd0, exp});
                end
            end
        end
        wr(2'd0, 8'h00);
        edge_pin = '0;
        settle(2);
        wr(2'd1, 8'h00);
        settle(3);

        // R5/R4: flag with enable off, then enable with write-1 to flag
        wr(2'd0, 8'h01);
        edge_pin[0] = 1'b1;
        settle(4);
        rdreg(2'd1, rd);
        check("R4 flag set", {31'd0, rd[4]}, 32'd1);
        check("R5 irq masked", {29'd0, edge_irq}, 32'd0);
        check("R9 wake masked", {31'd0, wake}, 32'd0);
        wr(2'd1, 8'h71);                             // enable ch0, flags written 1
        settle(2);
        rdreg(2'd1, rd);
        check("R4 write1 keeps", {31'd0, rd[4]}, 32'd1);
        check("R5 irq enabled", {29'd0, edge_irq}, 32'd1);
        check("R9 wake enabled", {31'd0, wake}, 32'd1);

        // R7: clear, then re-arm
        wr(2'd1, 8'h01);
        settle(2);
        rdreg(2'd1, rd);
        check("R7 cleared", {31'd0, rd[4]}, 32'd0);
        check("R7 irq off", {29'd0, edge_irq}, 32'd0);
        check("R7 wake off", {31'd0, wake}, 32'd0);
        edge_pin[0] = 1'b0;
        settle(1);
        edge_pin[0] = 1'b1;
        settle(4);
        rdreg(2'd1, rd);
        check("R7 rearm", {31'd0, rd[4]}, 32'd1);
        wr(2'd1, 8'h00);
        settle(3);

        // R6: edge with clock stopped, channel 2 in both-edges mode
        wr(2'd0, 8'h30);
        wr(2'd1, 8'h04);
        settle(2);
        @(negedge clk);
        clk_run = 1'b0;
        #20;
        edge_pin[2] = 1'b1;
        #1;
        check("R6 wake no clock", {31'd0, wake}, 32'd1);
        rdreg(2'd1, rd);
        check("R6 flag waits clock", {31'd0, rd[6]}, 32'd0);
        check("R6 irq waits clock", {29'd0, edge_irq}, 32'd0);
        #20;
        clk_run = 1'b1;
        settle(4);
        rdreg(2'd1, rd);
        check("R6 flag after restart", {31'd0, rd[6]}, 32'd1);
        check("R6 irq after restart", {29'd0, edge_irq}, 32'd4);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        settle(3);

        // R9: level input with clock stopped
        wr(2'd2, 8'h80);
        @(negedge clk);
        clk_run = 1'b0;
        #20;
        lvl_pin_n[7] = 1'b0;
        #1;
        check("R9 level wake no clock", {31'd0, wake}, 32'd1);
        lvl_pin_n[7] = 1'b1;
        #1;
        check("R8 level no latch", {31'd0, lvl_irq}, 32'd0);
        check("R9 wake released", {31'd0, wake}, 32'd0);
        #20;
        clk_run = 1'b1;
        settle(1);

        // R8: exhaustive level enable x pin sweep
        for (int e = 0; e < 256; e++) begin
            lvl_pin_n = '1;
            wr(2'd2, e[7:0]);
            reg_addr = 2'd3;
            for (int p = 0; p < 256; p++) begin
                logic [7:0] act_exp;
                lvl_pin_n = p[7:0];
                #1;
                act_exp = ~p[7:0] & e[7:0];
                check("R8 lvl_irq", {31'd0, lvl_irq}, {31'd0, |act_exp});
                check("R8 status", {24'd0, reg_rdata}, {24'd0, act_exp});
                check("R9 wake level", {31'd0, wake}, {31'd0, |act_exp});
            end
        end
        lvl_pin_n = '1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule